// File: doc/BRIEF.md
# Mailbox Doorbell Interrupt Unit

This unit sits beside a two-port 64K x 18 memory. It gives each port a private interrupt line, and it gives each port one mailbox word at the top of the address space. The word at 0xFFFE is the left port's inbox. The word at 0xFFFF is the right port's inbox. When one port writes into its partner's inbox, the partner's active-low interrupt drops. When the partner opens its inbox, the interrupt is released. Opening means taking its chip enable and output enable low at that address.

The two inbox words are ordinary 18-bit storage, and the message they carry is chosen by software. The rest of the memory array is outside this block. For that reason only the two inbox words are held here, and a read of any other address returns zero on this block's read-data port.

Each port may hold back its own writes through an active-low busy input. A held-back write neither stores data nor rings a doorbell. A parameter turns the doorbell function off entirely. The two words then behave as plain storage.

Top module: `mbox_doorbell_unit`

## Requirements
- R1: A synchronous active-high reset sets both interrupt outputs high, clears both inbox words to zero and sets both read-data outputs to zero.
- R2: A write by the right port (ce_n=0, rw_n=0, busy_n=1) to address 0xFFFE drives l_int_n low from the next clock edge. It stays low until cleared.
- R3: When the left port drives ce_n=0 and oe_n=0 at address 0xFFFE, l_int_n returns high at the next edge, whatever rw_n is.
- R4: A write by the left port (ce_n=0, rw_n=0, busy_n=1) to address 0xFFFF drives r_int_n low from the next clock edge.
- R5: When the right port drives ce_n=0 and oe_n=0 at address 0xFFFF, r_int_n returns high at the next edge, whatever rw_n is.
- R6: While a port's busy_n is low, its writes change neither interrupt and leave both inbox words unchanged.
- R7: If a set and a clear of the same interrupt fall in the same cycle, the interrupt is low after that edge.
- R8: A read (ce_n=0, rw_n=1) of 0xFFFE or 0xFFFF returns the stored word on that port's rdata one cycle later. The value is the one held before any write in the same cycle. In any other cycle rdata is zero.
- R9: If both ports write the same inbox word in one cycle, the left port's data is stored.
- R10: With DOORBELL_EN=0, both interrupts stay high and the inbox words still store and read back as in R8.
- R11: A port's writes to its own inbox or to any non-inbox address set no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_rw_n | input | 1 | Left read (1) / write (0) |
| l_busy_n | input | 1 | Left write inhibit, active low |
| l_addr | input | 16 | Left address |
| l_wdata | input | 18 | Left write data |
| l_rdata | output | 18 | Left inbox read data |
| l_int_n | output | 1 | Left interrupt, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_rw_n | input | 1 | Right read (1) / write (0) |
| r_busy_n | input | 1 | Right write inhibit, active low |
| r_addr | input | 16 | Right address |
| r_wdata | input | 18 | Right write data |
| r_rdata | output | 18 | Right inbox read data |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
All results (the interrupt levels, the inbox contents and read data) are registered. Each one is due exactly one clock edge after the cycle in which its stimulus was presented. The bench applies each vector on a falling edge, lets one rising edge pass, and compares every output on the following falling edge. No response has any slack, so a lost or extra cycle is caught. A second instance built with the doorbell disabled receives the same stimulus. Its interrupts are checked high and its read data is checked equal to the first instance's on every step.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    parameter int ADDR_W  = 16;
    parameter int DATA_W  = 18;
    parameter int NUM_BOX = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    // Inbox k belongs to port k: 0 = left (0xFFFE), 1 = right (0xFFFF)
    localparam addr_t BOX_BASE = addr_t'({ADDR_W{1'b1}}) - addr_t'(NUM_BOX - 1);

    typedef struct packed {
        logic               write;   // enabled, write strobe, not inhibited
        logic               read;    // enabled, read direction
        logic               notice;  // enabled with output enable
        logic [NUM_BOX-1:0] hit;     // one-hot inbox match
    } port_op_t;

    function automatic logic [NUM_BOX-1:0] box_hit(input addr_t a);
        logic [NUM_BOX-1:0] h;
        for (int k = 0; k < NUM_BOX; k++)
            h[k] = (a == BOX_BASE + addr_t'(k));
        return h;
    endfunction

    function automatic word_t box_pick(input logic [NUM_BOX-1:0] h,
                                       input word_t [NUM_BOX-1:0] w);
        word_t v = '0;
        for (int k = 0; k < NUM_BOX; k++)
            if (h[k]) v |= w[k];
        return v;
    endfunction
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
(
    input  logic     ce_n,
    input  logic     oe_n,
    input  logic     rw_n,
    input  logic     busy_n,
    input  addr_t    addr,
    output port_op_t op
);
    always_comb begin
        op.write  = !ce_n && !rw_n && busy_n;
        op.read   = !ce_n &&  rw_n;
        op.notice = !ce_n && !oe_n;
        op.hit    = box_hit(addr);
    end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag #(
    parameter bit EN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic ring,
    input  logic ack,
    output logic int_n
);
    generate
        if (EN) begin : g_live
            always_ff @(posedge clk) begin
                if (rst)       int_n <= 1'b1;
                else if (ring) int_n <= 1'b0;   // set wins over clear
                else if (ack)  int_n <= 1'b1;
            end

            // R2 / R4 / R7: a ring always leaves the line low
            a_r7_ring_wins: assert property (@(posedge clk) disable iff (rst)
                ring |=> !int_n);
            // R3 / R5: an acknowledge without a ring releases the line
            a_r3_ack_release: assert property (@(posedge clk) disable iff (rst)
                (ack && !ring) |=> int_n);
            // line only moves when commanded
            a_r2_hold: assert property (@(posedge clk) disable iff (rst)
                (!ring && !ack) |=> $stable(int_n));
        end else begin : g_off
            always_ff @(posedge clk) int_n <= 1'b1;
            wire unused_ok = ring ^ ack ^ rst;

            a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> int_n);
        end
    endgenerate
endmodule

// File: rtl/mbx_store.sv
module mbx_store
    import mbx_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  port_op_t [1:0]           op,
    input  word_t    [1:0]           wdata,
    output word_t    [1:0]           rdata
);
    word_t [NUM_BOX-1:0] box_q;

    genvar k, p;
    generate
        for (k = 0; k < NUM_BOX; k++) begin : g_box
            always_ff @(posedge clk) begin
                if (rst)
                    box_q[k] <= '0;
                else if (op[0].write && op[0].hit[k])   // left has priority
                    box_q[k] <= wdata[0];
                else if (op[1].write && op[1].hit[k])
                    box_q[k] <= wdata[1];
            end

            a_r9_left_wins: assert property (@(posedge clk) disable iff (rst)
                ($past(!rst) && $past(op[0].write && op[0].hit[k]))
                |-> box_q[k] == $past(wdata[0]));
            a_r6_no_write_keeps: assert property (@(posedge clk) disable iff (rst)
                ($past(!rst) && !$past(op[0].write && op[0].hit[k])
                             && !$past(op[1].write && op[1].hit[k]))
                |-> $stable(box_q[k]));
        end

        for (p = 0; p < 2; p++) begin : g_rd
            always_ff @(posedge clk) begin
                if (rst)
                    rdata[p] <= '0;
                else if (op[p].read && |op[p].hit)
                    rdata[p] <= box_pick(op[p].hit, box_q);
                else
                    rdata[p] <= '0;
            end

            a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
                !$past(op[p].read && |op[p].hit) |-> rdata[p] == '0);
        end
    endgenerate
endmodule

// File: rtl/mbox_doorbell_unit.sv
module mbox_doorbell_unit
    import mbx_pkg::*;
#(
    parameter bit DOORBELL_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_ce_n,
    input  logic              l_oe_n,
    input  logic              l_rw_n,
    input  logic              l_busy_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_int_n,
    input  logic              r_ce_n,
    input  logic              r_oe_n,
    input  logic              r_rw_n,
    input  logic              r_busy_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_int_n
);
    localparam int NPORT = 2;

    logic  [NPORT-1:0] ce_n, oe_n, rw_n, busy_n;
    addr_t [NPORT-1:0] addr;
    word_t [NPORT-1:0] wdata, rdata;
    port_op_t [NPORT-1:0] op;
    logic  [NPORT-1:0] int_n;

    assign ce_n   = {r_ce_n,   l_ce_n};
    assign oe_n   = {r_oe_n,   l_oe_n};
    assign rw_n   = {r_rw_n,   l_rw_n};
    assign busy_n = {r_busy_n, l_busy_n};
    assign addr   = {r_addr,   l_addr};
    assign wdata  = {r_wdata,  l_wdata};

    genvar p;
    generate
        for (p = 0; p < NPORT; p++) begin : g_port
            mbx_port_decode u_dec (
                .ce_n   (ce_n[p]),
                .oe_n   (oe_n[p]),
                .rw_n   (rw_n[p]),
                .busy_n (busy_n[p]),
                .addr   (addr[p]),
                .op     (op[p])
            );
            // port p's doorbell rings when the partner writes inbox p,
            // and is acknowledged when port p itself opens inbox p
            mbx_flag #(.EN(DOORBELL_EN)) u_flag (
                .clk   (clk),
                .rst   (rst),
                .ring  (op[NPORT-1-p].write && op[NPORT-1-p].hit[p]),
                .ack   (op[p].notice && op[p].hit[p]),
                .int_n (int_n[p])
            );
        end
    endgenerate

    mbx_store u_store (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .wdata (wdata),
        .rdata (rdata)
    );

    assign l_rdata = rdata[0];
    assign r_rdata = rdata[1];
    assign l_int_n = int_n[0];
    assign r_int_n = int_n[1];

    // R2 / R6: left line falls only after an uninhibited right write to 0xFFFE
    a_r2_left_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(l_int_n) |-> $past(!r_ce_n && !r_rw_n && r_busy_n
                                 && r_addr == BOX_BASE));
    // R4 / R6: right line falls only after an uninhibited left write to 0xFFFF
    a_r4_right_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(r_int_n) |-> $past(!l_ce_n && !l_rw_n && l_busy_n
                                 && l_addr == BOX_BASE + addr_t'(1)));
endmodule

// File: tb/mbox_doorbell_unit_test.sv
`timescale 1ns/1ps
module mbox_doorbell_unit_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;   // 200 MHz

    logic        l_ce_n, l_oe_n, l_rw_n, l_busy_n;
    logic [15:0] l_addr;
    logic [17:0] l_wdata;
    logic        r_ce_n, r_oe_n, r_rw_n, r_busy_n;
    logic [15:0] r_addr;
    logic [17:0] r_wdata;
    logic [17:0] l_rdata, r_rdata, p_l_rdata, p_r_rdata;
    logic        l_int_n, r_int_n, p_l_int_n, p_r_int_n;

    mbox_doorbell_unit uut (
        .clk(clk), .rst(rst),
        .l_ce_n(l_ce_n), .l_oe_n(l_oe_n), .l_rw_n(l_rw_n), .l_busy_n(l_busy_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_int_n(l_int_n),
        .r_ce_n(r_ce_n), .r_oe_n(r_oe_n), .r_rw_n(r_rw_n), .r_busy_n(r_busy_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_int_n(r_int_n)
    );

    // R10: same stimulus, doorbell disabled
    mbox_doorbell_unit #(.DOORBELL_EN(1'b0)) uut_plain (
        .clk(clk), .rst(rst),
        .l_ce_n(l_ce_n), .l_oe_n(l_oe_n), .l_rw_n(l_rw_n), .l_busy_n(l_busy_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(p_l_rdata), .l_int_n(p_l_int_n),
        .r_ce_n(r_ce_n), .r_oe_n(r_oe_n), .r_rw_n(r_rw_n), .r_busy_n(r_busy_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(p_r_rdata), .r_int_n(p_r_int_n)
    );

    // control triple = {ce_n, oe_n, rw_n}: 111 idle, 010 write, 001 read+open
    typedef struct packed {
        logic [2:0]  lc; logic lb; logic [15:0] la; logic [17:0] ld;
        logic [2:0]  rc; logic rb; logic [15:0] ra; logic [17:0] rd;
        logic        eil; logic eir; logic [17:0] erl; logic [17:0] err;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{3'b111,1'b1,16'h0000,18'h00000, 3'b111,1'b1,16'h0000,18'h00000, 1'b1,1'b1,18'h00000,18'h00000, 8'd1},  // R1 idle
        '{3'b111,1'b1,16'h0000,18'h00000, 3'b010,1'b1,16'hFFFE,18'h12345, 1'b0,1'b1,18'h00000,18'h00000, 8'd2},  // R2 ring left
        '{3'b111,1'b1,16'h0000,18'h00000, 3'b111,1'b1,16'h0000,18'h00000, 1'b0,1'b1,18'h00000,18'h00000, 8'd2},  // R2 holds
        '{3'b001,1'b1,16'hFFFE,18'h00000, 3'b111,1'b1,16'h0000,18'h00000, 1'b1,1'b1,18'h12345,18'h00000, 8'd3},  // R3 open, R8 data
        '{3'b010,1'b0,16'hFFFF,18'h3ABCD, 3'b111,1'b1,16'h0000,18'h00000, 1'b1,1'b1,18'h00000,18'h00000, 8'd6},  // R6 inhibited
        '{3'b111,1'b1,16'h0000,18'h00000, 3'b001,1'b1,16'hFFFF,18'h00000, 1'b1,1'b1,18'h00000,18'h00000, 8'd6},  // R6 word kept
        '{3'b010,1'b1,16'hFFFF,18'h3ABCD, 3'b111,1'b1,16'h0000,18'h00000, 1'b1,1'b0,18'h00000,18'h00000, 8'd4},  // R4 ring right
        '{3'b010,1'b1,16'hFFFE,18'h00001, 3'b111,1'b1,16'h0000,18'h00000, 1'b1,1'b0,18'h00000,18'h00000, 8'd11}, // R11 own inbox
        '{3'b001,1'b1,16'hFFFE,18'h00000, 3'b010,1'b1,16'hFFFE,18'h2AAAA, 1'b0,1'b0,18'h00001,18'h00000, 8'd7},  // R7 set beats clear
        '{3'b111,1'b1,16'h0000,18'h00000, 3'b001,1'b1,16'hFFFF,18'h00000, 1'b0,1'b1,18'h00000,18'h3ABCD, 8'd5},  // R5 open right
        '{3'b010,1'b1,16'hFFFF,18'h11111, 3'b010,1'b1,16'hFFFF,18'h22222, 1'b0,1'b0,18'h00000,18'h00000, 8'd9},  // R9 collision
        '{3'b111,1'b1,16'h0000,18'h00000, 3'b001,1'b1,16'hFFFF,18'h00000, 1'b0,1'b1,18'h00000,18'h11111, 8'd9},  // R9 left kept
        '{3'b010,1'b1,16'h0100,18'h3FFFF, 3'b010,1'b1,16'h7FFE,18'h15555, 1'b0,1'b1,18'h00000,18'h00000, 8'd11}, // R11 plain addrs
        '{3'b001,1'b1,16'hFFFE,18'h00000, 3'b111,1'b1,16'h0000,18'h00000, 1'b1,1'b1,18'h2AAAA,18'h00000, 8'd3},  // R3 again
        '{3'b001,1'b1,16'h0100,18'h00000, 3'b111,1'b1,16'h0000,18'h00000, 1'b1,1'b1,18'h00000,18'h00000, 8'd8},  // R8 non-inbox
        '{3'b111,1'b1,16'h0000,18'h00000, 3'b010,1'b0,16'hFFFE,18'h00777, 1'b1,1'b1,18'h00000,18'h00000, 8'd6},  // R6 right held
        '{3'b001,1'b1,16'hFFFE,18'h00000, 3'b111,1'b1,16'h0000,18'h00000, 1'b1,1'b1,18'h2AAAA,18'h00000, 8'd6}   // R6 word kept
    };

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input int req, input string what,
                         input logic [17:0] act, input logic [17:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        {l_ce_n, l_oe_n, l_rw_n} = v.lc; l_busy_n = v.lb; l_addr = v.la; l_wdata = v.ld;
        {r_ce_n, r_oe_n, r_rw_n} = v.rc; r_busy_n = v.rb; r_addr = v.ra; r_wdata = v.rd;
    endtask

    task automatic idle();
        {l_ce_n, l_oe_n, l_rw_n} = 3'b111; l_busy_n = 1'b1; l_addr = '0; l_wdata = '0;
        {r_ce_n, r_oe_n, r_rw_n} = 3'b111; r_busy_n = 1'b1; r_addr = '0; r_wdata = '0;
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        // R1: state held in reset
        check(1, "reset l_int_n", {17'd0, l_int_n}, 18'd1);
        check(1, "reset r_int_n", {17'd0, r_int_n}, 18'd1);
        check(1, "reset l_rdata", l_rdata, 18'd0);
        check(1, "reset r_rdata", r_rdata, 18'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            @(negedge clk);
            check(int'(TBL[i].req), $sformatf("vec %0d l_int_n", i), {17'd0, l_int_n}, {17'd0, TBL[i].eil});
            check(int'(TBL[i].req), $sformatf("vec %0d r_int_n", i), {17'd0, r_int_n}, {17'd0, TBL[i].eir});
            check(int'(TBL[i].req), $sformatf("vec %0d l_rdata", i), l_rdata, TBL[i].erl);
            check(int'(TBL[i].req), $sformatf("vec %0d r_rdata", i), r_rdata, TBL[i].err);
            // R10: disabled doorbell stays quiet, storage unchanged
            check(10, $sformatf("vec %0d plain ints", i), {16'd0, p_l_int_n, p_r_int_n}, 18'd3);
            check(10, $sformatf("vec %0d plain l_rdata", i), p_l_rdata, TBL[i].erl);
            check(10, $sformatf("vec %0d plain r_rdata", i), p_r_rdata, TBL[i].err);
        end

        // R1: reset in mid-run clears a pending doorbell and the inbox words
        {r_ce_n, r_oe_n, r_rw_n} = 3'b010; r_addr = 16'hFFFE; r_wdata = 18'h0BEEF;
        @(negedge clk);
        check(2, "pre-reset ring", {17'd0, l_int_n}, 18'd0);
        idle();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(1, "mid reset l_int_n", {17'd0, l_int_n}, 18'd1);
        check(1, "mid reset r_int_n", {17'd0, r_int_n}, 18'd1);
        {l_ce_n, l_oe_n, l_rw_n} = 3'b001; l_addr = 16'hFFFE;
        @(negedge clk);
        check(1, "inbox cleared by reset", l_rdata, 18'd0);
        idle();
        @(negedge clk);
        check(8, "rdata zero when idle", l_rdata, 18'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule